// File: doc/BRIEF.md
# Three-Stage Accumulator Processor Core

This block is a compact 8-bit processor built around one accumulator. Instructions are bytes held in a 96-entry internal program store. They move through three pipeline stages: fetch, decode, and a final stage that executes and writes back in the same cycle. Every ALU result lands in the accumulator. Eight general-purpose registers supply the second ALU operand and take accumulator stores. A 16-byte data RAM and an eight-entry hardware return stack complete the machine state.

Instructions that carry an immediate value, a RAM address or a jump target take two bytes. Decode holds the opcode byte and treats the next fetched byte as its operand, never as an opcode. Taken jumps, calls and returns squash the two younger bytes in the pipeline and restart fetch at the new address.

Program bytes are written through a load port. While that port is active the pipeline is frozen. The accumulator and the fetch address are visible on debug outputs.

Top module: `acc_core`

## Requirements
- R1: Reset is asynchronous and active-low and is released through a two-stage synchronizer. While reset is held, `dbg_acc` and `dbg_pc` read 0. Reset also clears the flags and all eight registers.
- R2: In straight-line code the fetch address advances by one each cycle and wraps from 95 to 0. It never exceeds 95.
- R3: While `load_en` is high, the byte on `load_data` is written to program address `load_addr` if that address is below 96, and the pipeline holds all of its state.
- R4: The opcode is in bits [7:4] and the register or condition field is in bits [2:0]. The ALU opcodes are 4 ADD, 5 SUB, 6 ADC (add with carry in), 7 RSH and 8 LSH. Each writes its result to the accumulator. Carry is the carry-out for ADD and ADC, the borrow (a < b) for SUB, the bit shifted out of bit 0 for RSH, and the bit shifted out of bit 7 for LSH.
- R5: The flags are zero, MSB (result bit 7) and carry. Only ALU opcodes update them. Opcode 11 (jump) tests condition field 0 always, 1 Z, 2 not Z, 3 M, 4 not M, 5 C, 6 not C, 7 never.
- R6: Opcodes 1 (load immediate), 9 (load RAM), 10 (store RAM), 11 (jump) and 12 (call) take two bytes. The second byte is used only as an operand, even when it sits at address 0 after a wrap.
- R7: A taken jump, a call or a return (opcode 13) discards the two instructions behind it. Fetch resumes at the target on the next cycle.
- R8: A call pushes its own address plus 2. A return pops that address. The stack holds 8 entries; a push into a full stack overwrites the oldest entry, and a pop from an empty stack yields address 0.
- R9: The RAM opcodes use the low 4 bits of the operand as the RAM address.
- R10: Opcode 2 copies register [2:0] into the accumulator, and opcode 3 copies the accumulator into register [2:0]. An instruction that reads a value written by the instruction just before it sees the new value, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Program write strobe; freezes the pipeline while high |
| load_addr | input | 7 | Program byte address for writes |
| load_data | input | 8 | Program byte to write |
| dbg_acc | output | 8 | Current accumulator value |
| dbg_pc | output | 7 | Current fetch address |

## Verification
The assertions check the following on every cycle:
- the fetch address stays in range and holds while loading;
- the execute slot is empty after every redirect;
- the flags are untouched by non-ALU instructions;
- a held opcode issues with the following byte as its operand;
- the stack depth never exceeds eight and grows by one on each push below full.

The bench's programs are the only way to show end-to-end behaviour: arithmetic results and carries over a sweep of operand pairs, branch conditions, the return address, overwrite of the oldest stack entry on overflow, and pops from an empty stack.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_LDI  = 4'd1,
    OP_MOV  = 4'd2,
    OP_STR  = 4'd3,
    OP_ADD  = 4'd4,
    OP_SUB  = 4'd5,
    OP_ADC  = 4'd6,
    OP_RSH  = 4'd7,
    OP_LSH  = 4'd8,
    OP_LDM  = 4'd9,
    OP_STM  = 4'd10,
    OP_JMP  = 4'd11,
    OP_CALL = 4'd12,
    OP_RET  = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } op_e;

  typedef enum logic [2:0] {
    FN_ADD,
    FN_SUB,
    FN_ADC,
    FN_RSH,
    FN_LSH
  } alu_fn_e;

  typedef struct packed {
    logic z;
    logic m;
    logic c;
  } flags_t;

  function automatic logic is_two_word(op_e op);
    return op inside {OP_LDI, OP_LDM, OP_STM, OP_JMP, OP_CALL};
  endfunction

  function automatic logic is_alu(op_e op);
    return op inside {OP_ADD, OP_SUB, OP_ADC, OP_RSH, OP_LSH};
  endfunction

  function automatic logic cond_met(logic [2:0] cc, flags_t f);
    case (cc)
      3'd0:    return 1'b1;
      3'd1:    return f.z;
      3'd2:    return !f.z;
      3'd3:    return f.m;
      3'd4:    return !f.m;
      3'd5:    return f.c;
      3'd6:    return !f.c;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_core_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  alu_fn_e      fn,
  output logic [W-1:0] y,
  output logic         cout
);

  logic [W:0] wide;

  always_comb begin
    wide = '0;
    case (fn)
      FN_ADD:  wide = {1'b0, a} + {1'b0, b};
      FN_SUB:  wide = {1'b0, a} - {1'b0, b};
      FN_ADC:  wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
      FN_RSH:  wide = {a[0], 1'b0, a[W-1:1]};
      FN_LSH:  wide = {a, 1'b0};
      default: wide = '0;
    endcase
    y    = wide[W-1:0];
    cout = wide[W];
  end

endmodule

// File: rtl/acc_fetch.sv
module acc_fetch #(
  parameter int DEPTH = 96,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          load_en,
  input  logic [AW-1:0] load_addr,
  input  logic [7:0]    load_data,
  input  logic          redirect,
  input  logic [AW-1:0] redirect_pc,
  output logic [AW-1:0] pc_o,
  output logic [7:0]    word_o,
  output logic [AW-1:0] word_pc_o,
  output logic          word_vld_o
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [7:0]    prog_q [DEPTH];
  logic [AW-1:0] pc_q, pc_d, wpc_q, wpc_d;
  logic [7:0]    word_q, word_d;
  logic          vld_q, vld_d;

  always_ff @(posedge clk) begin
    if (load_en && (load_addr < AW'(DEPTH))) prog_q[load_addr] <= load_data;
  end

  always_comb begin
    pc_d   = pc_q;
    word_d = word_q;
    wpc_d  = wpc_q;
    vld_d  = vld_q;
    if (en) begin
      if (redirect) begin
        pc_d  = redirect_pc;
        vld_d = 1'b0;
      end else begin
        word_d = prog_q[pc_q];
        wpc_d  = pc_q;
        vld_d  = 1'b1;
        pc_d   = (pc_q == LAST) ? '0 : pc_q + AW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      word_q <= '0;
      wpc_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      word_q <= word_d;
      wpc_q  <= wpc_d;
      vld_q  <= vld_d;
    end
  end

  assign pc_o       = pc_q;
  assign word_o     = word_q;
  assign word_pc_o  = wpc_q;
  assign word_vld_o = vld_q;

  p_pc_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q <= LAST);

  p_hold_while_loading_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(pc_q) && $stable(vld_q));

endmodule

// File: rtl/acc_callstack.sv
module acc_callstack #(
  parameter int DEPTH = 8,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_addr,
  output logic [AW-1:0] top_addr
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] PLAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL  = CW'(DEPTH);

  logic [AW-1:0] slot_q [DEPTH];
  logic [PW-1:0] ptr_q, ptr_d, ptr_inc, ptr_dec;
  logic [CW-1:0] cnt_q, cnt_d;

  assign ptr_inc  = (ptr_q == PLAST) ? '0 : ptr_q + PW'(1);
  assign ptr_dec  = (ptr_q == '0) ? PLAST : ptr_q - PW'(1);
  assign top_addr = (cnt_q == '0) ? '0 : slot_q[ptr_dec];

  always_ff @(posedge clk) begin
    if (push) slot_q[ptr_q] <= push_addr;
  end

  always_comb begin
    ptr_d = ptr_q;
    cnt_d = cnt_q;
    if (push) begin
      ptr_d = ptr_inc;
      cnt_d = (cnt_q == FULL) ? cnt_q : cnt_q + CW'(1);
    end else if (pop && (cnt_q != '0)) begin
      ptr_d = ptr_dec;
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      cnt_q <= cnt_d;
    end
  end

  p_depth_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);

  p_push_grows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && (cnt_q < FULL)) |=> cnt_q == $past(cnt_q) + CW'(1));

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int PROG_DEPTH  = 96,
  parameter int RAM_DEPTH   = 16,
  parameter int STACK_DEPTH = 8,
  parameter int NREGS       = 8,
  localparam int PAW = $clog2(PROG_DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_en,
  input  logic [PAW-1:0] load_addr,
  input  logic [7:0]     load_data,
  output logic [7:0]     dbg_acc,
  output logic [PAW-1:0] dbg_pc
);

  localparam int RAW  = $clog2(RAM_DEPTH);
  localparam int RSEL = $clog2(NREGS);

  // reset: asserted at once, released after two clock edges
  logic rst_meta_q, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  logic en;
  assign en = !load_en;

  // fetch
  logic           flush;
  logic [PAW-1:0] redirect_pc, f_pc, f_wpc;
  logic [7:0]     f_word;
  logic           f_vld;

  acc_fetch #(.DEPTH(PROG_DEPTH), .AW(PAW)) u_fetch (
    .clk(clk), .rst_n(rst_core_n), .en(en),
    .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
    .redirect(flush), .redirect_pc(redirect_pc),
    .pc_o(f_pc), .word_o(f_word), .word_pc_o(f_wpc), .word_vld_o(f_vld)
  );

  // decode: holds the opcode of a two-byte instruction until its operand arrives
  op_e            f_op;
  logic           pend_q, pend_d;
  op_e            pend_op_q, pend_op_d;
  logic [2:0]     pend_fld_q, pend_fld_d;
  logic [PAW-1:0] pend_pc_q, pend_pc_d;
  logic           ex_vld_q, ex_vld_d;
  op_e            ex_op_q, ex_op_d;
  logic [2:0]     ex_fld_q, ex_fld_d;
  logic [7:0]     ex_imm_q, ex_imm_d;
  logic [PAW-1:0] ex_pc_q, ex_pc_d;

  assign f_op = op_e'(f_word[7:4]);

  always_comb begin
    pend_d     = pend_q;
    pend_op_d  = pend_op_q;
    pend_fld_d = pend_fld_q;
    pend_pc_d  = pend_pc_q;
    ex_vld_d   = ex_vld_q;
    ex_op_d    = ex_op_q;
    ex_fld_d   = ex_fld_q;
    ex_imm_d   = ex_imm_q;
    ex_pc_d    = ex_pc_q;
    if (en) begin
      ex_vld_d = 1'b0;
      if (flush) begin
        pend_d = 1'b0;
      end else if (f_vld) begin
        if (pend_q) begin
          ex_vld_d = 1'b1;
          ex_op_d  = pend_op_q;
          ex_fld_d = pend_fld_q;
          ex_imm_d = f_word;
          ex_pc_d  = pend_pc_q;
          pend_d   = 1'b0;
        end else if (is_two_word(f_op)) begin
          pend_d     = 1'b1;
          pend_op_d  = f_op;
          pend_fld_d = f_word[2:0];
          pend_pc_d  = f_wpc;
        end else begin
          ex_vld_d = 1'b1;
          ex_op_d  = f_op;
          ex_fld_d = f_word[2:0];
          ex_imm_d = '0;
          ex_pc_d  = f_wpc;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      pend_q     <= 1'b0;
      pend_op_q  <= OP_NOP;
      pend_fld_q <= '0;
      pend_pc_q  <= '0;
      ex_vld_q   <= 1'b0;
      ex_op_q    <= OP_NOP;
      ex_fld_q   <= '0;
      ex_imm_q   <= '0;
      ex_pc_q    <= '0;
    end else begin
      pend_q     <= pend_d;
      pend_op_q  <= pend_op_d;
      pend_fld_q <= pend_fld_d;
      pend_pc_q  <= pend_pc_d;
      ex_vld_q   <= ex_vld_d;
      ex_op_q    <= ex_op_d;
      ex_fld_q   <= ex_fld_d;
      ex_imm_q   <= ex_imm_d;
      ex_pc_q    <= ex_pc_d;
    end
  end

  // execute / writeback
  logic [7:0]      acc_q, acc_d;
  flags_t          flags_q, flags_d;
  logic [7:0]      regs_q [NREGS];
  logic [7:0]      ram_q  [RAM_DEPTH];
  logic [RSEL-1:0] rsel;
  logic [RAW-1:0]  ram_idx;
  logic            reg_we, ram_we, do_push, do_pop;
  logic [PAW-1:0]  ret_addr, stack_top, jump_tgt;
  logic [PAW:0]    pc_plus2;
  alu_fn_e         fn;
  logic [7:0]      alu_y;
  logic            alu_c;

  assign rsel     = ex_fld_q[RSEL-1:0];
  assign ram_idx  = ex_imm_q[RAW-1:0];
  assign pc_plus2 = {1'b0, ex_pc_q} + (PAW+1)'(2);
  assign ret_addr = (pc_plus2 >= (PAW+1)'(PROG_DEPTH)) ?
                    PAW'(pc_plus2 - (PAW+1)'(PROG_DEPTH)) : PAW'(pc_plus2);
  assign jump_tgt = (ex_imm_q < 8'(PROG_DEPTH)) ? PAW'(ex_imm_q) : '0;

  always_comb begin
    case (ex_op_q)
      OP_SUB:  fn = FN_SUB;
      OP_ADC:  fn = FN_ADC;
      OP_RSH:  fn = FN_RSH;
      OP_LSH:  fn = FN_LSH;
      default: fn = FN_ADD;
    endcase
  end

  acc_alu #(.W(8)) u_alu (
    .a(acc_q), .b(regs_q[rsel]), .cin(flags_q.c), .fn(fn), .y(alu_y), .cout(alu_c)
  );

  acc_callstack #(.DEPTH(STACK_DEPTH), .AW(PAW)) u_stack (
    .clk(clk), .rst_n(rst_core_n), .push(do_push), .pop(do_pop),
    .push_addr(ret_addr), .top_addr(stack_top)
  );

  always_comb begin
    acc_d       = acc_q;
    flags_d     = flags_q;
    reg_we      = 1'b0;
    ram_we      = 1'b0;
    flush       = 1'b0;
    do_push     = 1'b0;
    do_pop      = 1'b0;
    redirect_pc = jump_tgt;
    if (en && ex_vld_q) begin
      case (ex_op_q)
        OP_LDI: acc_d  = ex_imm_q;
        OP_MOV: acc_d  = regs_q[rsel];
        OP_STR: reg_we = 1'b1;
        OP_LDM: acc_d  = ram_q[ram_idx];
        OP_STM: ram_we = 1'b1;
        OP_JMP: flush  = cond_met(ex_fld_q, flags_q);
        OP_CALL: begin
          flush   = 1'b1;
          do_push = 1'b1;
        end
        OP_RET: begin
          flush       = 1'b1;
          do_pop      = 1'b1;
          redirect_pc = stack_top;
        end
        default: begin
          if (is_alu(ex_op_q)) begin
            acc_d   = alu_y;
            flags_d = '{z: (alu_y == 8'h00), m: alu_y[7], c: alu_c};
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (ram_we) ram_q[ram_idx] <= acc_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      acc_q   <= '0;
      flags_q <= '0;
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else begin
      acc_q   <= acc_d;
      flags_q <= flags_d;
      if (reg_we) regs_q[rsel] <= acc_q;
    end
  end

  assign dbg_acc = acc_q;
  assign dbg_pc  = f_pc;

  p_squash_after_redirect_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    flush |=> !ex_vld_q);

  p_flags_only_alu_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (en && ex_vld_q && !is_alu(ex_op_q)) |=> $stable(flags_q));

  p_operand_joins_opcode_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (en && !flush && pend_q && f_vld) |=> ex_vld_q && (ex_op_q == $past(pend_op_q)));

endmodule

// File: tb/acc_core_bench.sv
module acc_core_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_en = 1'b0;
  logic [6:0] load_addr = '0;
  logic [7:0] load_data = '0;
  logic [7:0] dbg_acc;
  logic [6:0] dbg_pc;

  int checks = 0;
  int errors = 0;

  logic [7:0] pb [96];
  int         plen;

  always #2 clk = ~clk;

  acc_core u_acc_core (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .dbg_acc(dbg_acc), .dbg_pc(dbg_pc)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic pclear();
    for (int i = 0; i < 96; i++) pb[i] = 8'h00;
    plen = 0;
  endtask

  task automatic put(input logic [7:0] b);
    pb[plen] = b;
    plen++;
  endtask

  task automatic put_at(input int a, input logic [7:0] b);
    pb[a] = b;
    if (a + 1 > plen) plen = a + 1;
  endtask

  // jump with condition cc: taken leaves 0x22 in the accumulator, else 0x11
  task automatic tail_branch(input logic [2:0] cc);
    int s;
    s = plen;
    put({5'b10110, cc}); put(8'(s + 6));
    put(8'h10); put(8'h11);
    put(8'hB0); put(8'(s + 4));
    put(8'h10); put(8'h22);
    put(8'hB0); put(8'(s + 8));
  endtask

  task automatic run(input int cyc);
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < plen; i++) begin
      load_en = 1'b1; load_addr = 7'(i); load_data = pb[i];
      @(negedge clk);
    end
    load_en = 1'b0;
    rst_n = 1'b1;
    repeat (cyc) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] a, b, er, ec;
    logic [6:0] p0, prev;
    logic [3:0] ops [4];
    ops[0] = 4'd4; ops[1] = 4'd5; ops[2] = 4'd7; ops[3] = 4'd8;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 acc in reset", dbg_acc, 8'h00);
    check("R1 pc in reset", {1'b0, dbg_pc}, 8'h00);

    // R1: registers cleared (MOV r6 after reset)
    pclear(); put(8'h10); put(8'h5A); put(8'h26); put(8'hB0); put(8'h03);
    run(40);
    check("R1 register cleared", dbg_acc, 8'h00);

    // R2: NOP sled, consecutive addresses with wrap 95 -> 0
    pclear(); plen = 96;
    run(5);
    for (int i = 0; i < 200; i++) begin
      prev = dbg_pc;
      @(negedge clk);
      check("R2 pc step", {1'b0, dbg_pc}, 8'((prev == 7'd95) ? 0 : prev + 1));
    end

    // R3: load_en freezes the pipeline
    p0 = dbg_pc;
    load_en = 1'b1; load_addr = 7'd95; load_data = 8'h00;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R3 pc held while loading", {1'b0, dbg_pc}, {1'b0, p0});
    end
    load_en = 1'b0;
    @(negedge clk);
    check("R3 pc resumes", {1'b0, dbg_pc}, 8'((p0 == 7'd95) ? 0 : p0 + 1));

    // R4: operand sweep over ADD, SUB, RSH, LSH: result and carry
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 16; i++) begin
        for (int j = 0; j < 8; j++) begin
          a = 8'(i * 17);
          b = 8'(j * 37 + 5);
          case (k)
            0: begin er = a + b; ec = {7'd0, ({1'b0, a} + {1'b0, b}) > 9'd255}; end
            1: begin er = a - b; ec = {7'd0, a < b}; end
            2: begin er = a >> 1; ec = {7'd0, a[0]}; end
            default: begin er = a << 1; ec = {7'd0, a[7]}; end
          endcase
          pclear();
          put(8'h10); put(b); put(8'h31); put(8'h10); put(a); put({ops[k], 4'h1});
          put(8'hB0); put(8'h06);
          run(40);
          check("R4 alu result", dbg_acc, er);
          pclear();
          put(8'h10); put(b); put(8'h31); put(8'h10); put(a); put({ops[k], 4'h1});
          put(8'hB5); put(8'h0C); put(8'h10); put(8'h00); put(8'hB0); put(8'h0A);
          put(8'h10); put(8'h01); put(8'hB0); put(8'h0E);
          run(40);
          check("R4 alu carry", dbg_acc, ec);
        end
      end
    end

    // R4: ADC uses the carry from the previous ADD
    pclear(); put(8'h10); put(8'hFF); put(8'h31); put(8'h41); put(8'h61);
    put(8'hB0); put(8'h05);
    run(40);
    check("R4 adc with carry in", dbg_acc, 8'hFE);

    // R5: zero flag and its inverse
    pclear(); put(8'h10); put(8'h05); put(8'h31); put(8'h51); tail_branch(3'd1);
    run(60);
    check("R5 jump on Z", dbg_acc, 8'h22);
    pclear(); put(8'h10); put(8'h05); put(8'h31); put(8'h51); tail_branch(3'd2);
    run(60);
    check("R5 jump on not Z", dbg_acc, 8'h11);
    pclear(); put(8'h10); put(8'h05); put(8'h31); put(8'h51); tail_branch(3'd6);
    run(60);
    check("R5 jump on not C", dbg_acc, 8'h22);
    // R5: MSB flag
    pclear(); put(8'h10); put(8'h40); put(8'h31); put(8'h41); tail_branch(3'd3);
    run(60);
    check("R5 jump on M", dbg_acc, 8'h22);
    pclear(); put(8'h10); put(8'h40); put(8'h31); put(8'h41); tail_branch(3'd4);
    run(60);
    check("R5 jump on not M", dbg_acc, 8'h11);
    pclear(); tail_branch(3'd7);
    run(60);
    check("R5 never jump", dbg_acc, 8'h11);
    // R5: a load of zero leaves Z clear and C set
    pclear(); put(8'h10); put(8'hFF); put(8'h31); put(8'h41); put(8'h10); put(8'h00);
    tail_branch(3'd1);
    run(60);
    check("R5 load leaves Z", dbg_acc, 8'h11);
    pclear(); put(8'h10); put(8'hFF); put(8'h31); put(8'h41); put(8'h10); put(8'h00);
    put(8'h32); tail_branch(3'd5);
    run(60);
    check("R5 load and store leave C", dbg_acc, 8'h22);

    // R6: immediate that looks like an opcode
    pclear(); put(8'h10); put(8'hD0); put(8'hB0); put(8'h02);
    run(40);
    check("R6 operand not decoded", dbg_acc, 8'hD0);
    // R6 / R2: jump whose target byte wraps to address 0
    pclear();
    put_at(0, 8'h0C); put_at(1, 8'hB0); put_at(2, 8'h5F);
    put_at(12, 8'h10); put_at(13, 8'h99); put_at(14, 8'hB0); put_at(15, 8'h0E);
    put_at(95, 8'hB0);
    run(60);
    check("R6 operand across wrap", dbg_acc, 8'h99);

    // R7: the two instructions after a taken jump are discarded
    pclear(); put(8'h10); put(8'h03); put(8'h31); put(8'h10); put(8'h00);
    put(8'hB0); put(8'h09); put(8'h41); put(8'h41); put(8'h41); put(8'hB0); put(8'h0A);
    run(60);
    check("R7 jump squash", dbg_acc, 8'h03);

    // R8 / R7: call, return to call address + 2, squash after return
    pclear();
    put_at(0, 8'hC0); put_at(1, 8'h0A); put_at(2, 8'h24); put_at(3, 8'hB0); put_at(4, 8'h03);
    put_at(10, 8'h10); put_at(11, 8'h21); put_at(12, 8'h34); put_at(13, 8'h10);
    put_at(14, 8'h00); put_at(15, 8'hD0); put_at(16, 8'h34); put_at(17, 8'h34);
    run(80);
    check("R8 call and return", dbg_acc, 8'h21);

    // R8: nine nested calls, oldest overwritten, ninth return goes to 0
    pclear();
    put(8'h10); put(8'h00); put(8'h45); put(8'hB2); put(8'd60);
    put(8'h10); put(8'h01); put(8'h31); put(8'h10); put(8'h00);
    for (int lv = 0; lv < 9; lv++) begin
      put(8'hC0); put(8'(10 + 5 * (lv + 1))); put(8'h41); put(8'h35); put(8'hD0);
    end
    put(8'hD0);
    put_at(60, 8'h25); put_at(61, 8'hB0); put_at(62, 8'd61);
    run(300);
    check("R8 stack overflow and empty pop", dbg_acc, 8'h08);

    // R9: RAM address is the low 4 bits of the operand
    pclear(); put(8'h10); put(8'h6B); put(8'hA0); put(8'h13); put(8'h10); put(8'h00);
    put(8'h90); put(8'h03); put(8'hB0); put(8'h08);
    run(50);
    check("R9 ram low bits", dbg_acc, 8'h6B);
    pclear(); put(8'h10); put(8'h11); put(8'hA0); put(8'h24); put(8'h10); put(8'h22);
    put(8'hA0); put(8'h05); put(8'h90); put(8'h14); put(8'hB0); put(8'h0A);
    run(50);
    check("R9 ram separate cells", dbg_acc, 8'h11);

    // R10: back-to-back dependent instructions
    pclear(); put(8'h10); put(8'h07); put(8'h33); put(8'h10); put(8'h00); put(8'h23);
    put(8'h43); put(8'hB0); put(8'h07);
    run(50);
    check("R10 dependent chain", dbg_acc, 8'h0E);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule